// File: doc/BRIEF.md
# Ones-Complement Adder/Subtractor

This block adds or subtracts two signed words held in ones-complement form, where the most significant bit is the sign (0 for positive). A negative value is the bitwise inverse of the positive value with the same magnitude. A single mode input chooses the operation. In add mode the second operand goes straight to the adder. In subtract mode each of its bits is inverted first, so the adder forms the minuend plus the ones complement of the subtrahend.

The carry out of the main addition is folded back in as an end-around carry. A second, carry-free increment stage adds it to the raw sum, so the netlist has no combinational loop. The result is left as the adder produces it: either zero encoding (all zeros or all ones) can appear, and both raise the zero flag. A signed-overflow flag reports when the true result falls outside the range the word can hold. The block is purely combinational.

Top module: `oc_addsub`

## Requirements
- R1: With `sub_mode` = 0, `result` is the ones-complement encoding of `op_a` + `op_b` whenever no overflow occurs.
- R2: With `sub_mode` = 1, every bit of `op_b` is inverted before the adder, and `result` encodes `op_a` − `op_b` whenever no overflow occurs; subtracting any word from itself gives all ones.
- R3: `carry_out` is bit W of the unsigned sum of `op_a` and the conditioned `op_b`, taken before the end-around carry is applied. Adding two positive words never sets it, and adding two negative words always sets it.
- R4: When `carry_out` is 1, `result` is the low W bits of that sum plus one. When `carry_out` is 0, `result` equals those low bits. Example: 0101 + 1100 gives `carry_out` = 1 and `result` = 0010.
- R5: `zero` is 1 exactly when `result` is 0000 or 1111 (all bits equal). Adding a word to its bitwise inverse gives 1111 with `zero` = 1.
- R6: `overflow` is 1 exactly when the true signed result lies outside ±(2^(W−1)−1). This is the case where `op_a` and the conditioned `op_b` share a sign bit and the sign bit of `result` differs from it. Operands of unlike conditioned sign never overflow.
- R7: `result` is not normalised. 0000 + 0000 gives 0000, 0101 + 1010 gives 1111, 1111 + 1111 gives 1111, and 0000 − 1111 gives 0000.
- R8: All outputs depend only on the present inputs; the block holds no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_a | input | W | First operand / minuend, ones-complement |
| op_b | input | W | Second operand / subtrahend, ones-complement |
| sub_mode | input | 1 | 0 = add, 1 = subtract (invert `op_b`) |
| result | output | W | Ones-complement sum after end-around carry |
| carry_out | output | 1 | Carry of the main addition before folding |
| zero | output | 1 | Result is either zero encoding |
| overflow | output | 1 | Signed overflow |

## Verification
Every result is combinational and settles within the cycle in which the operands change; no result waits for a clock edge. The bench applies a new operand pair just after each rising edge and samples `result`, `carry_out`, `zero` and `overflow` at the following falling edge, so each check sees the settled outputs for that pair only. The expected values come from signed ones-complement value arithmetic across every operand pair in both modes, plus seeded random pairs and directed zero-encoding cases.

// File: rtl/oc_pkg.sv
package oc_pkg;

  typedef enum logic {
    OC_ADD = 1'b0,
    OC_SUB = 1'b1
  } oc_mode_e;

  // Full adder: returns {carry, sum}
  function automatic logic [1:0] oc_fa(input logic a, input logic b, input logic c);
    return {(a & b) | (a & c) | (b & c), a ^ b ^ c};
  endfunction

  // Half adder: returns {carry, sum}
  function automatic logic [1:0] oc_ha(input logic a, input logic b);
    return {a & b, a ^ b};
  endfunction

endpackage

// File: rtl/oc_true_comp.sv
module oc_true_comp #(
  parameter int W = 4
) (
  input  logic [W-1:0] din,
  input  logic         inv,
  output logic [W-1:0] dout
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    assign dout[i] = din[i] ^ inv;
  end
endmodule

// File: rtl/oc_ripple.sv
module oc_ripple
  import oc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic         cin,
  output logic [W-1:0] sum,
  output logic         cout
);
  logic [W:0] c;
  assign c[0] = cin;
  for (genvar i = 0; i < W; i++) begin : g_fa
    assign {c[i+1], sum[i]} = oc_fa(a[i], b[i], c[i]);
  end
  assign cout = c[W];
endmodule

// File: rtl/oc_incr.sv
module oc_incr
  import oc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] din,
  input  logic         inc,
  output logic [W-1:0] dout
);
  // The folded carry can never ripple out of the top bit, so the chain stops at W-1
  logic [W-1:0] c;
  assign c[0] = inc;
  for (genvar i = 0; i < W; i++) begin : g_ha
    if (i < W - 1) begin : g_mid
      assign {c[i+1], dout[i]} = oc_ha(din[i], c[i]);
    end else begin : g_top
      assign dout[i] = din[i] ^ c[i];
    end
  end
endmodule

// File: rtl/oc_flags.sv
module oc_flags #(
  parameter int W = 4
) (
  input  logic         a_sign,
  input  logic         b_sign,
  input  logic [W-1:0] res,
  output logic         zero,
  output logic         overflow
);
  assign zero     = (&res) | ~(|res);
  assign overflow = (a_sign == b_sign) && (res[W-1] != a_sign);
endmodule

// File: rtl/oc_addsub.sv
module oc_addsub
  import oc_pkg::*;
#(
  parameter int W = 4
) (
  input  logic [W-1:0] op_a,
  input  logic [W-1:0] op_b,
  input  logic         sub_mode,
  output logic [W-1:0] result,
  output logic         carry_out,
  output logic         zero,
  output logic         overflow
);
  oc_mode_e    mode;
  logic        invert_b;
  logic [W-1:0] cond_b;
  logic [W-1:0] raw_sum;
  logic        eac;

  assign mode     = oc_mode_e'(sub_mode);
  assign invert_b = (mode == OC_SUB);

  oc_true_comp #(.W(W)) u_tc (
    .din (op_b),
    .inv (invert_b),
    .dout(cond_b)
  );

  oc_ripple #(.W(W)) u_add (
    .a   (op_a),
    .b   (cond_b),
    .cin (1'b0),
    .sum (raw_sum),
    .cout(eac)
  );

  oc_incr #(.W(W)) u_eac (
    .din (raw_sum),
    .inc (eac),
    .dout(result)
  );

  oc_flags #(.W(W)) u_flags (
    .a_sign  (op_a[W-1]),
    .b_sign  (cond_b[W-1]),
    .res     (result),
    .zero    (zero),
    .overflow(overflow)
  );

  assign carry_out = eac;
endmodule

// File: rtl/oc_addsub_chk.sv
module oc_addsub_chk #(
  parameter int W = 4
) (
  input logic [W-1:0] op_a,
  input logic [W-1:0] op_b,
  input logic         sub_mode,
  input logic [W-1:0] cond_b,
  input logic [W-1:0] result,
  input logic         carry_out,
  input logic         zero,
  input logic         overflow
);
  always_comb begin
    if (!sub_mode && (op_a == ~op_b)) begin
      p_cancel_zero_r5: assert (zero && (result == {W{1'b1}}))
        else $error("cancel to zero failed");
    end
    if (sub_mode && (op_a == op_b)) begin
      p_self_sub_r2: assert (result == {W{1'b1}})
        else $error("self subtract failed");
    end
    if (op_a[W-1] != cond_b[W-1]) begin
      p_no_overflow_r6: assert (!overflow)
        else $error("overflow on unlike signs");
    end
    if (!sub_mode && !op_a[W-1] && !op_b[W-1]) begin
      p_pos_carry_r3: assert (!carry_out)
        else $error("carry on two positives");
    end
    if (!sub_mode && op_a[W-1] && op_b[W-1]) begin
      p_neg_carry_r3: assert (carry_out)
        else $error("no carry on two negatives");
    end
  end
endmodule

bind oc_addsub oc_addsub_chk #(.W(W)) u_chk (
  .op_a     (op_a),
  .op_b     (op_b),
  .sub_mode (sub_mode),
  .cond_b   (cond_b),
  .result   (result),
  .carry_out(carry_out),
  .zero     (zero),
  .overflow (overflow)
);

// File: tb/sim_oc_addsub.sv
`timescale 1ns/1ps
module sim_oc_addsub;
  localparam int W    = 4;
  localparam int MASK = (1 << W) - 1;
  localparam int HI   = (1 << (W - 1)) - 1;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [W-1:0] op_a = '0;
  logic [W-1:0] op_b = '0;
  logic         sub_mode = 1'b0;
  logic [W-1:0] result;
  logic         carry_out, zero, overflow;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  oc_addsub #(.W(W)) u0 (
    .op_a(op_a), .op_b(op_b), .sub_mode(sub_mode),
    .result(result), .carry_out(carry_out), .zero(zero), .overflow(overflow)
  );

  function automatic int sval(input int x);
    return ((x >> (W - 1)) & 1) ? -((~x) & MASK) : (x & MASK);
  endfunction

  function automatic int true_val(input int a, input int b, input bit s);
    return s ? sval(a) - sval(b) : sval(a) + sval(b);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s a=%0h b=%0h sub=%0b actual=%0d expected=%0d",
               tag, op_a, op_b, sub_mode, act, exp);
    end
  endtask

  task automatic apply(input int a, input int b, input bit s);
    @(posedge clk);
    #1;
    op_a = a[W-1:0];
    op_b = b[W-1:0];
    sub_mode = s;
    @(negedge clk);
  endtask

  // Full check of one settled operand pair
  task automatic check_pair();
    int a, bc, t, s, low, expr;
    bit ovf, c;
    a   = int'(op_a);
    bc  = sub_mode ? ((~int'(op_b)) & MASK) : int'(op_b);
    s   = a + bc;
    c   = (s >> W) & 1;
    low = s & MASK;
    expr = c ? ((low + 1) & MASK) : low;
    t   = true_val(int'(op_a), int'(op_b), sub_mode);
    ovf = (t > HI) || (t < -HI);
    chk("R3", int'(carry_out), int'(c));
    chk("R4", int'(result), expr);
    chk("R5", int'(zero), int'((expr == 0) || (expr == MASK)));
    chk("R6", int'(overflow), int'(ovf));
    if (!ovf) begin
      if (sub_mode) chk("R2", sval(int'(result)), t);
      else          chk("R1", sval(int'(result)), t);
    end
  endtask

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R8: outputs follow inputs with no state; all-zero inputs give zero
    chk("R8", int'(result), 0);
    chk("R8", int'(zero), 1);
    chk("R8", int'(overflow), 0);

    // R7 directed zero encodings
    apply(4'b0000, 4'b0000, 1'b0); chk("R7", int'(result), 4'b0000); chk("R7", int'(zero), 1);
    apply(4'b0101, 4'b1010, 1'b0); chk("R7", int'(result), 4'b1111); chk("R7", int'(zero), 1);
    apply(4'b1111, 4'b1111, 1'b0); chk("R7", int'(result), 4'b1111); chk("R7", int'(zero), 1);
    apply(4'b0000, 4'b1111, 1'b1); chk("R7", int'(result), 4'b0000); chk("R7", int'(zero), 1);
    apply(4'b0011, 4'b0011, 1'b1); chk("R2", int'(result), 4'b1111);
    // R4 end-around carry: 5 + (-3)
    apply(4'b0101, 4'b1100, 1'b0); chk("R4", int'(carry_out), 1); chk("R4", int'(result), 4'b0010);
    // R6 overflow at both ends
    apply(4'b0111, 4'b0001, 1'b0); chk("R6", int'(overflow), 1);
    apply(4'b1000, 4'b1110, 1'b0); chk("R6", int'(overflow), 1); chk("R6", int'(result), 4'b0111);
    apply(4'b0111, 4'b1000, 1'b1); chk("R6", int'(overflow), 1);
    apply(4'b0110, 4'b0001, 1'b0); chk("R6", int'(overflow), 0); chk("R1", int'(result), 4'b0111);

    // Exhaustive sweep of every pair in both modes
    for (int m = 0; m < 2; m++)
      for (int a = 0; a <= MASK; a++)
        for (int b = 0; b <= MASK; b++) begin
          apply(a, b, m[0]);
          check_pair();
        end

    // Seeded random pairs
    for (int k = 0; k < 300; k++) begin
      apply(int'($urandom & MASK), int'($urandom & MASK), bit'($urandom & 1));
      check_pair();
    end

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule